// File: doc/BRIEF.md
# Signed/Unsigned Sequential Shift-Add Multiplier

This block multiplies two WIDTH-bit operands one multiplier bit per clock cycle and delivers a 2*WIDTH-bit product. A caller raises `start` while the block is not busy. The operands and the signedness selector are captured on that edge. For WIDTH cycles the block adds either the multiplicand or zero to the upper half of an accumulator, depending on the current multiplier bit, and then shifts the whole accumulator right by one position. The result appears on `product`, `done` pulses once, and the product is held until the next accepted start.

The adder is WIDTH+1 bits wide, so the bit that enters the top of the accumulator on each shift is the true sign (signed mode) or the carry (unsigned mode) of the addition. In signed mode the most significant multiplier bit has negative weight, so the last step subtracts the multiplicand instead of adding it. Because the accumulator shifts right, the multiplicand is never widened beyond WIDTH+1 bits.

The controller has three states. IDLE moves to RUN on start. RUN stays in RUN while the step counter is below WIDTH-1 and moves to DONE on the last step. DONE moves to RUN on start and otherwise returns to IDLE. Reset forces IDLE.

Top module: `shiftadd_mult`

## Requirements
- R1: After reset, `busy` and `done` are 0 and `product` is 0.
- R2: With `signed_mode`=1, the product equals the two's-complement product of `op_a` and `op_b`, sign-extended to 2*WIDTH bits.
- R3: With `signed_mode`=0, the product equals the unsigned product of `op_a` and `op_b`.
- R4: `done` is high for exactly one cycle. It rises on the WIDTH-th rising edge after the edge that accepted `start`.
- R5: `busy` is high for exactly WIDTH consecutive cycles after an accepted start.
- R6: A `start` asserted while `busy` is high is ignored. The running operation completes with its original operands, and no extra result is produced.
- R7: While `busy` is low and `start` is low, `product` does not change.
- R8: `op_a`, `op_b` and `signed_mode` are sampled only on the edge that accepts `start`. Changing them during a run has no effect on the result.
- R9: Corner operands give exact results. These include the most negative value times itself in signed mode (2^(2*WIDTH-2)), all ones times all ones in unsigned mode, and zero operands.
- R10: `busy` and `done` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a multiplication; accepted when busy is low |
| signed_mode | input | 1 | 1: two's-complement operands, 0: unsigned operands |
| op_a | input | WIDTH | Multiplicand |
| op_b | input | WIDTH | Multiplier, consumed LSB first |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse when product is valid |
| product | output | 2*WIDTH | Result, held until the next accepted start |

## Verification
The bench targets the most negative value squared. A design that drops the adder's extra bit or shifts in the wrong sign gets a negative or truncated result here, and a design that adds instead of subtracting on the last step gets the sign of every negative-multiplier product wrong. Unsigned all-ones operands expose a missing carry bit at the top. A design that re-latches operands on a start during a run, or that samples mode or operands after the accept edge, returns the product of the wrong numbers. An off-by-one step counter shows up as a wrong busy length, a misplaced done pulse, and a product scaled by two.

// File: rtl/smul_pkg.sv
package smul_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } smul_state_e;
endpackage

// File: rtl/smul_ctrl.sv
module smul_ctrl
    import smul_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic load,
    output logic step,
    output logic last,
    output logic busy,
    output logic done
);
    localparam int CW = (WIDTH > 2) ? $clog2(WIDTH) : 1;
    localparam logic [CW-1:0] LAST_IDX = CW'(WIDTH - 1);

    smul_state_e state_q, state_d;
    logic [CW-1:0] cnt_q;

    // state register and step counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (load)      cnt_q <= '0;
            else if (step) cnt_q <= cnt_q + 1'b1;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_RUN;
            ST_RUN:  if (cnt_q == LAST_IDX) state_d = ST_DONE;
            ST_DONE: state_d = start ? ST_RUN : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        load = 1'b0;
        step = 1'b0;
        busy = 1'b0;
        done = 1'b0;
        unique case (state_q)
            ST_IDLE: load = start;
            ST_RUN: begin
                step = 1'b1;
                busy = 1'b1;
            end
            ST_DONE: begin
                done = 1'b1;
                load = start;
            end
            default: ;
        endcase
        last = step && (cnt_q == LAST_IDX);
    end
endmodule

// File: rtl/smul_datapath.sv
module smul_datapath #(
    parameter int WIDTH = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               step,
    input  logic               last,
    input  logic               signed_mode,
    input  logic [WIDTH-1:0]   op_a,
    input  logic [WIDTH-1:0]   op_b,
    output logic [2*WIDTH-1:0] product
);
    localparam int EW = WIDTH + 1;

    logic [WIDTH-1:0] mcand_q;
    logic [WIDTH-1:0] acc_hi_q;
    logic [WIDTH-1:0] acc_lo_q;
    logic             sgn_q;

    logic [EW-1:0] hi_ext, mc_ext, addend, sum;
    logic          subtract;

    always_comb begin
        hi_ext   = {sgn_q & acc_hi_q[WIDTH-1], acc_hi_q};
        mc_ext   = {sgn_q & mcand_q[WIDTH-1], mcand_q};
        addend   = acc_lo_q[0] ? mc_ext : '0;
        subtract = last && sgn_q;
        sum      = subtract ? (hi_ext - addend) : (hi_ext + addend);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mcand_q  <= '0;
            acc_hi_q <= '0;
            acc_lo_q <= '0;
            sgn_q    <= 1'b0;
        end else if (load) begin
            mcand_q  <= op_a;
            acc_hi_q <= '0;
            acc_lo_q <= op_b;
            sgn_q    <= signed_mode;
        end else if (step) begin
            acc_hi_q <= sum[EW-1:1];
            acc_lo_q <= {sum[0], acc_lo_q[WIDTH-1:1]};
        end
    end

    assign product = {acc_hi_q, acc_lo_q};
endmodule

// File: rtl/shiftadd_mult.sv
module shiftadd_mult #(
    parameter int WIDTH = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               signed_mode,
    input  logic [WIDTH-1:0]   op_a,
    input  logic [WIDTH-1:0]   op_b,
    output logic               busy,
    output logic               done,
    output logic [2*WIDTH-1:0] product
);
    logic load, step, last;

    smul_ctrl #(.WIDTH(WIDTH)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .load  (load),
        .step  (step),
        .last  (last),
        .busy  (busy),
        .done  (done)
    );

    smul_datapath #(.WIDTH(WIDTH)) u_dp (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (load),
        .step        (step),
        .last        (last),
        .signed_mode (signed_mode),
        .op_a        (op_a),
        .op_b        (op_b),
        .product     (product)
    );
endmodule

// File: rtl/shiftadd_mult_chk.sv
module shiftadd_mult_chk #(
    parameter int WIDTH = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start,
    input logic               busy,
    input logic               done,
    input logic [2*WIDTH-1:0] product
);
    localparam int LW = $clog2(WIDTH + 1) + 1;
    logic [LW-1:0] run_len_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    run_len_q <= '0;
        else if (busy) run_len_q <= run_len_q + 1'b1;
        else           run_len_q <= '0;
    end

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R4
    AST_DONE_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n) $rose(done) |-> $past(busy)); // R4
    AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> run_len_q == LW'(WIDTH)); // R5
    AST_PRODUCT_HELD: assert property (@(posedge clk) disable iff (!rst_n) (!busy && !start) |=> $stable(product)); // R7
    AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(busy && done)); // R10
endmodule

bind shiftadd_mult shiftadd_mult_chk #(.WIDTH(WIDTH)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .product (product)
);

// File: tb/shiftadd_mult_tb_top.sv
`timescale 1ns/1ps
module shiftadd_mult_tb_top;
    localparam int W = 8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start = 1'b0;
    logic           signed_mode = 1'b0;
    logic [W-1:0]   op_a = '0;
    logic [W-1:0]   op_b = '0;
    logic           busy, done;
    logic [2*W-1:0] product;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    shiftadd_mult #(.WIDTH(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .signed_mode(signed_mode),
        .op_a(op_a), .op_b(op_b), .busy(busy), .done(done), .product(product)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [2*W-1:0] ref_mul(input logic [W-1:0] a, input logic [W-1:0] b,
                                               input logic sm);
        logic [2*W-1:0] r;
        if (sm) r = $signed(a) * $signed(b);
        else    r = a * b;
        return r;
    endfunction

    // issue start at a negedge, then wait for done; returns cycles counted
    task automatic launch(input logic [W-1:0] a, input logic [W-1:0] b, input logic sm,
                          output int cyc);
        op_a = a; op_b = b; signed_mode = sm; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (!done && cyc < 4*W) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    task automatic run_one(input string req, input logic [W-1:0] a, input logic [W-1:0] b,
                           input logic sm);
        int cyc;
        launch(a, b, sm, cyc);
        check(req, product, ref_mul(a, b, sm));
        @(negedge clk);
    endtask

    task automatic t_reset_state();
        check("R1 busy", busy, 0);
        check("R1 done", done, 0);
        check("R1 product", product, 0);
    endtask

    task automatic t_signed_directed();
        run_one("R2 3*5", 8'd3, 8'd5, 1'b1);
        run_one("R2 -3*5", 8'hFD, 8'd5, 1'b1);
        run_one("R2 7*-2", 8'd7, 8'hFE, 1'b1);
        run_one("R2 -1*-1", 8'hFF, 8'hFF, 1'b1);
        run_one("R2 127*-128", 8'd127, 8'h80, 1'b1);
    endtask

    task automatic t_unsigned_directed();
        run_one("R3 200*3", 8'd200, 8'd3, 1'b0);
        run_one("R3 128*128", 8'h80, 8'h80, 1'b0);
        run_one("R3 255*1", 8'hFF, 8'd1, 1'b0);
    endtask

    task automatic t_corners();
        run_one("R9 min*min signed", 8'h80, 8'h80, 1'b1);
        check("R9 min*min value", product, 16'h4000);
        run_one("R9 ones*ones unsigned", 8'hFF, 8'hFF, 1'b0);
        check("R9 ones*ones value", product, 16'hFE01);
        run_one("R9 zero*neg", 8'd0, 8'h81, 1'b1);
        run_one("R9 neg*zero", 8'h81, 8'd0, 1'b1);
        run_one("R9 zero*zero", 8'd0, 8'd0, 1'b0);
    endtask

    task automatic t_timing();
        int cyc;
        op_a = 8'd9; op_b = 8'hF3; signed_mode = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R5 busy after accept", busy, 1);
        cyc = 0;
        while (!done && cyc < 4*W) begin
            check("R10 busy/done exclusive", busy & done, 0);
            @(negedge clk);
            cyc++;
        end
        check("R4 cycles to done", cyc, W);
        check("R5 busy low at done", busy, 0);
        check("R2 timing product", product, ref_mul(8'd9, 8'hF3, 1'b1));
        @(negedge clk);
        check("R4 done single cycle", done, 0);
    endtask

    task automatic t_start_while_busy();
        int cyc;
        int extra;
        op_a = 8'h85; op_b = 8'd6; signed_mode = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        op_a = 8'd11; op_b = 8'd13; signed_mode = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 4;
        while (!done && cyc < 4*W) begin
            @(negedge clk);
            cyc++;
        end
        check("R6 original result", product, ref_mul(8'h85, 8'd6, 1'b1));
        check("R6 no restart timing", cyc, W);
        extra = 0;
        repeat (2*W) begin
            @(negedge clk);
            if (busy || done) extra++;
        end
        check("R6 no second operation", extra, 0);
        check("R7 product held", product, ref_mul(8'h85, 8'd6, 1'b1));
    endtask

    task automatic t_inputs_change();
        op_a = 8'hC8; op_b = 8'hB1; signed_mode = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        op_a = 8'd1; op_b = 8'd1; signed_mode = 1'b0;
        while (!done) @(negedge clk);
        check("R8 late input change", product, ref_mul(8'hC8, 8'hB1, 1'b1));
        @(negedge clk);
    endtask

    task automatic t_random();
        for (int i = 0; i < 60; i++) begin
            logic [W-1:0] a, b;
            logic sm;
            a = W'($urandom);
            b = W'($urandom);
            sm = 1'($urandom);
            run_one(sm ? "R2 random" : "R3 random", a, b, sm);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset_state();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_signed_directed();
        t_unsigned_directed();
        t_corners();
        t_timing();
        t_start_while_busy();
        t_inputs_change();
        t_random();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule